// File: doc/BRIEF.md
# Eighth-Rate Quadrature Output Mixer

This block moves a decimated sample stream up or down in frequency by one eighth of its own sample rate. Each accepted sample is scaled by a selectable gain of one or two. It is then multiplied by one step of an eight-step cosine/sine rotation, which gives an in-phase and a quadrature output. The rotation position is held in a three-bit phase counter. The counter steps once per accepted sample and wraps from 7 to 0.

A two-bit start-state input picks one of four even rotation positions. A sync strobe reloads the phase counter from that start state, so several parallel channels can be aligned to a common rotation phase. A disable input bypasses the rotation. In bypass, the scaled real input appears on the I output and the Q output is zero. Complex pass-through of a separate I/Q input pair is chosen only when the disable and the complex-output enable are both set. Every result is registered, with one cycle of latency from an accepted input to its output.

Top module: `fs8_mixer`

## Requirements
- R1: The phase counter steps by one (modulo 8) for each cycle with `in_valid` high, whether the rotation is enabled or bypassed. For counter value k, the I coefficient is cos(k·45°) and the Q coefficient is sin(k·45°). These take the values +1, +0.7071, 0, -0.7071 and -1, where 0.7071 is the signed constant 23170 out of 32768. While rotating, I = x·cos and Q = x·sin, where x is the scaled `in_i`.
- R2: When `sync` is high, the phase counter loads 2·`start_state` (0, 2, 4 or 6). A sample accepted in the same cycle uses the loaded phase, and the counter then steps from it.
- R3: In a cycle with both `in_valid` and `sync` low, the phase counter keeps its value.
- R4: Each product is rounded by adding 2^14 and shifting right arithmetically by 15. It is then saturated to the range -32768..32767. For example, -32768 times -1 gives 32767.
- R5: With `gain_one` high, the sample reaches the rotation unchanged. With `gain_one` low, the sample is doubled and saturated to 16 bits instead of wrapping. The same gain is applied to both the I and the Q input.
- R6: With `mix_disable` high and `complex_en` low, `out_i` is the scaled `in_i` and `out_q` is 0.
- R7: `out_q` carries the scaled `in_q` only when `mix_disable` and `complex_en` are both high. With `mix_disable` low, `complex_en` has no effect on either output.
- R8: `out_valid` equals `in_valid` delayed by one cycle. The outputs update one cycle after an accepted sample and hold their values across cycles with `in_valid` low.
- R9: While `rst_n` is low, `out_valid`, `out_i` and `out_q` are 0 and the phase counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | Real / in-phase input sample, signed |
| in_q | input | 16 | Quadrature input sample for complex pass-through, signed |
| sync | input | 1 | Reloads the phase counter from the start state |
| start_state | input | 2 | Selects the reload phase 0, 2, 4 or 6 |
| gain_one | input | 1 | 1: gain of one; 0: gain of two with saturation |
| mix_disable | input | 1 | Bypasses the rotation |
| complex_en | input | 1 | With `mix_disable`, passes `in_q` to `out_q` |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | In-phase output, signed |
| out_q | output | 16 | Quadrature output, signed |

## Verification
The bench builds the block with its defaults: 16-bit samples and 23170 as the 45° coefficient. At this width the saturation limits of -32768 and 32767 can be reached directly. That covers both the doubled-gain clamp and the single overflowing case of the rotation, a full-scale negative sample times -1. With the default coefficient, a full pass of all eight rotation steps, sync reloads to each even phase, and the bypass and complex-select combinations can all be checked against exact hand-derivable values.

// File: rtl/fs8_mixer_pkg.sv
`timescale 1ns/1ps
package fs8_mixer_pkg;
  localparam int PHASE_W   = 3;
  localparam int START_W   = 2;
  localparam int N_LANES   = 2;
  localparam int LANE_I    = 0;
  localparam int LANE_Q    = 1;
endpackage

// File: rtl/fs8_phase_gen.sv
`timescale 1ns/1ps
module fs8_phase_gen
  import fs8_mixer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_en,
  input  logic               sync,
  input  logic [START_W-1:0] start_state,
  output logic [PHASE_W-1:0] phase_use
);
  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] phase_d;
  logic               phase_en;

  // phase applied to the current sample: a reload takes effect at once
  always_comb begin
    phase_use = sync ? {start_state, 1'b0} : phase_q;
    phase_en  = step_en | sync;
    phase_d   = step_en ? PHASE_W'(phase_use + 1'b1) : phase_use;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (phase_en) phase_q <= phase_d;
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !sync) |=> $stable(phase_q));
  p_sync_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && !step_en) |=> phase_q == {$past(start_state), 1'b0});
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !sync) |=> phase_q == PHASE_W'($past(phase_q) + 1'b1));
endmodule

// File: rtl/fs8_gain_lane.sv
`timescale 1ns/1ps
module fs8_gain_lane #(
  parameter int DATA_W = 16
) (
  input  logic              gain_one,
  input  logic [DATA_W-1:0] x,
  output logic [DATA_W-1:0] y
);
  localparam logic [DATA_W-1:0] SAT_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] SAT_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic overflow;

  always_comb begin
    overflow = x[DATA_W-1] ^ x[DATA_W-2];
    if (gain_one)      y = x;
    else if (overflow) y = x[DATA_W-1] ? SAT_MIN : SAT_MAX;
    else               y = {x[DATA_W-2:0], 1'b0};
  end

  // doubling must never flip the sign of a nonzero sample
  always_comb begin
    if (!gain_one && (x != '0))
      p_sign_kept_r5: assert (y[DATA_W-1] == x[DATA_W-1]);
  end
endmodule

// File: rtl/fs8_rotator.sv
`timescale 1ns/1ps
module fs8_rotator
  import fs8_mixer_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COEF_HALF = 23170
) (
  input  logic [PHASE_W-1:0] phase,
  input  logic [DATA_W-1:0]  x_i,
  input  logic [DATA_W-1:0]  x_q,
  input  logic               mix_disable,
  input  logic               complex_en,
  output logic [DATA_W-1:0]  y_i,
  output logic [DATA_W-1:0]  y_q
);
  localparam int CW = DATA_W + 1;
  localparam int PW = 2 * DATA_W + 1;
  localparam logic signed [CW-1:0] C_UNIT = {2'b01, {(DATA_W-1){1'b0}}};
  localparam logic signed [CW-1:0] C_HALF = CW'(COEF_HALF);
  localparam logic signed [PW-1:0] RND  = {{(DATA_W+2){1'b0}}, 1'b1, {(DATA_W-2){1'b0}}};
  localparam logic signed [PW-1:0] PMAX = {{(DATA_W+2){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [PW-1:0] PMIN = {{(DATA_W+2){1'b1}}, {(DATA_W-1){1'b0}}};

  function automatic logic signed [CW-1:0] coef_at(input logic [PHASE_W-1:0] k);
    case (k)
      3'd0:    coef_at = C_UNIT;
      3'd1:    coef_at = C_HALF;
      3'd3:    coef_at = -C_HALF;
      3'd4:    coef_at = -C_UNIT;
      3'd5:    coef_at = -C_HALF;
      3'd7:    coef_at = C_HALF;
      default: coef_at = '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] mul_rnd(input logic signed [DATA_W-1:0] x,
                                                input logic signed [CW-1:0] c);
    logic signed [PW-1:0] p;
    logic signed [PW-1:0] s;
    p = PW'(x) * PW'(c);
    s = (p + RND) >>> (DATA_W - 1);
    if (s > PMAX)      mul_rnd = PMAX[DATA_W-1:0];
    else if (s < PMIN) mul_rnd = PMIN[DATA_W-1:0];
    else               mul_rnd = s[DATA_W-1:0];
  endfunction

  logic [PHASE_W-1:0] sin_idx;

  always_comb begin
    sin_idx = PHASE_W'(phase + 3'd6);
    if (!mix_disable) begin
      y_i = mul_rnd(x_i, coef_at(phase));
      y_q = mul_rnd(x_i, coef_at(sin_idx));
    end else begin
      y_i = x_i;
      y_q = complex_en ? x_q : '0;
    end
  end
endmodule

// File: rtl/fs8_mixer.sv
`timescale 1ns/1ps
module fs8_mixer
  import fs8_mixer_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COEF_HALF = 23170
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_i,
  input  logic [DATA_W-1:0] in_q,
  input  logic              sync,
  input  logic [1:0]        start_state,
  input  logic              gain_one,
  input  logic              mix_disable,
  input  logic              complex_en,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_i,
  output logic [DATA_W-1:0] out_q
);
  logic [PHASE_W-1:0] phase;
  logic [DATA_W-1:0]  lane_in  [N_LANES];
  logic [DATA_W-1:0]  lane_out [N_LANES];
  logic [DATA_W-1:0]  rot_i, rot_q;
  logic [DATA_W-1:0]  out_i_d, out_q_d;
  logic               out_valid_d;

  fs8_phase_gen u_phase (
    .clk(clk), .rst_n(rst_n), .step_en(in_valid), .sync(sync),
    .start_state(start_state), .phase_use(phase)
  );

  assign lane_in[LANE_I] = in_i;
  assign lane_in[LANE_Q] = in_q;

  for (genvar g = 0; g < N_LANES; g++) begin : g_gain
    fs8_gain_lane #(.DATA_W(DATA_W)) u_gain (
      .gain_one(gain_one), .x(lane_in[g]), .y(lane_out[g])
    );
  end

  fs8_rotator #(.DATA_W(DATA_W), .COEF_HALF(COEF_HALF)) u_rot (
    .phase(phase), .x_i(lane_out[LANE_I]), .x_q(lane_out[LANE_Q]),
    .mix_disable(mix_disable), .complex_en(complex_en),
    .y_i(rot_i), .y_q(rot_q)
  );

  always_comb begin
    out_valid_d = in_valid;
    out_i_d     = rot_i;
    out_q_d     = rot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= out_valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_i <= '0;
      out_q <= '0;
    end else if (in_valid) begin
      out_i <= out_i_d;
      out_q <= out_q_d;
    end
  end

  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_i) && $stable(out_q) && !out_valid));
  p_bypass_q_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mix_disable && !complex_en) |=> (out_q == '0));
  p_quarter_null_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mix_disable && (phase[0] == 1'b0) && (phase[1] == 1'b1))
      |=> (out_i == '0));
endmodule

// File: tb/fs8_mixer_test.sv
`timescale 1ns/1ps
module fs8_mixer_test;
  localparam int DW = 16;
  localparam int HALF = 23170;

  typedef struct packed {
    logic v, s;
    logic [1:0] st;
    logic dis, cx, g1;
    logic signed [15:0] xi, xq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b1,2'd0,1'b0,1'b0,1'b1, 16'sd10000, 16'sd0},   // R2 sync to 0
    '{1'b1,1'b0,2'd0,1'b0,1'b0,1'b1, 16'sd10000, 16'sd0},   // R1 steps
    '{1'b1,1'b0,2'd0,1'b0,1'b0,1'b1, 16'sd10000, 16'sd0},
    '{1'b1,1'b0,2'd0,1'b0,1'b0,1'b1, 16'sd10000, 16'sd0},
    '{1'b1,1'b0,2'd0,1'b0,1'b0,1'b1, 16'sd10000, 16'sd0},
    '{1'b1,1'b0,2'd0,1'b0,1'b0,1'b1, 16'sd10000, 16'sd0},
    '{1'b1,1'b0,2'd0,1'b0,1'b0,1'b1, 16'sd10000, 16'sd0},
    '{1'b1,1'b0,2'd0,1'b0,1'b0,1'b1, 16'sd10000, 16'sd0},
    '{1'b1,1'b0,2'd0,1'b0,1'b0,1'b1, -16'sd7777, 16'sd0},   // R1 wrap to 0
    '{1'b0,1'b0,2'd0,1'b0,1'b0,1'b1, 16'sd555,   16'sd0},   // R3 R8 idle
    '{1'b1,1'b0,2'd0,1'b0,1'b0,1'b1, 16'sd1000,  16'sd0},   // phase 1
    '{1'b1,1'b1,2'd1,1'b0,1'b0,1'b1, -16'sd12345,16'sd0},   // R2 same-cycle
    '{1'b0,1'b1,2'd3,1'b0,1'b0,1'b1, 16'sd0,     16'sd0},   // R2 sync alone
    '{1'b1,1'b0,2'd0,1'b0,1'b0,1'b1, 16'sd3000,  16'sd0},   // phase 6
    '{1'b1,1'b0,2'd0,1'b0,1'b0,1'b0, 16'sd20000, 16'sd0},   // R5 R4 phase 7
    '{1'b1,1'b0,2'd0,1'b0,1'b0,1'b0, -16'sd9000, 16'sd0},   // R5 phase 0
    '{1'b1,1'b0,2'd0,1'b1,1'b0,1'b1, -16'sd5000, 16'sd777}, // R6
    '{1'b1,1'b0,2'd0,1'b1,1'b1,1'b1, -16'sd5000, 16'sd777}, // R7 complex
    '{1'b1,1'b0,2'd0,1'b0,1'b1,1'b1, 16'sd4000,  16'sd777}, // R7 no effect
    '{1'b1,1'b0,2'd0,1'b1,1'b1,1'b0, -16'sd20000,16'sd777}, // R5 R7
    '{1'b1,1'b1,2'd2,1'b0,1'b0,1'b1, -16'sd32768,16'sd0},   // R4 sat at -1
    '{1'b1,1'b1,2'd2,1'b0,1'b0,1'b1, 16'sd32767, 16'sd0}    // R4 phase 4
  };

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, sync, gain_one, mix_disable, complex_en;
  logic [1:0] start_state;
  logic [DW-1:0] in_i, in_q;
  logic out_valid;
  logic [DW-1:0] out_i, out_q;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fs8_mixer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .sync(sync), .start_state(start_state), .gain_one(gain_one),
    .mix_disable(mix_disable), .complex_en(complex_en),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  // reference state
  int m_phase;
  int e_i, e_q;
  bit e_v;

  function automatic int coefm(input int k);
    case (k & 7)
      0: return 32768;
      1: return HALF;
      3: return -HALF;
      4: return -32768;
      5: return -HALF;
      7: return HALF;
      default: return 0;
    endcase
  endfunction

  function automatic int clamp16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int mulm(input int x, input int c);
    longint p;
    p = longint'(x) * longint'(c);
    p = (p + 16384) >>> 15;
    return clamp16(p);
  endfunction

  function automatic int gainm(input int x, input bit g1);
    return g1 ? x : clamp16(longint'(x) * 2);
  endfunction

  task automatic chk(input string req, input int act, input int exp_v);
    n_checks++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic model(input vec_t t);
    int pu, gi, gq;
    pu = t.s ? 2 * int'(t.st) : m_phase;
    e_v = t.v;
    if (t.v) begin
      gi = gainm(int'(t.xi), t.g1);
      gq = gainm(int'(t.xq), t.g1);
      if (!t.dis) begin
        e_i = mulm(gi, coefm(pu));
        e_q = mulm(gi, coefm(pu + 6));
      end else begin
        e_i = gi;
        e_q = t.cx ? gq : 0;
      end
      m_phase = (pu + 1) & 7;
    end else if (t.s) begin
      m_phase = pu;
    end
  endtask

  task automatic drive(input vec_t t);
    in_valid = t.v; sync = t.s; start_state = t.st;
    mix_disable = t.dis; complex_en = t.cx; gain_one = t.g1;
    in_i = t.xi; in_q = t.xq;
  endtask

  task automatic idle();
    in_valid = 0; sync = 0; start_state = 0; mix_disable = 0;
    complex_en = 0; gain_one = 1; in_i = 0; in_q = 0;
  endtask

  task automatic check_out(input string req);
    chk({req, " valid"}, int'(out_valid), int'(e_v));
    chk({req, " I"}, int'($signed(out_i)), e_i);
    chk({req, " Q"}, int'($signed(out_q)), e_q);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle();
    m_phase = 0; e_i = 0; e_q = 0; e_v = 0;
    @(negedge clk);
    check_out("R9 reset");
    rst_n = 1'b1;
  endtask

  initial begin
    vec_t t;
    rst_n = 1'b0;
    idle();
    m_phase = 0; e_i = 0; e_q = 0; e_v = 0;
    repeat (3) @(negedge clk);
    check_out("R9 reset");
    rst_n = 1'b1;

    // table walk
    @(negedge clk);
    for (int k = 0; k < NV; k++) begin
      drive(VEC[k]);
      model(VEC[k]);
      @(negedge clk);
      check_out($sformatf("R1 R2 R3 R4 R5 R6 R7 R8 vec %0d", k));
    end

    // directed: saturation corners of R4
    t = '{1'b1,1'b1,2'd2,1'b0,1'b0,1'b1,-16'sd32768,16'sd0};
    drive(t); model(t); @(negedge clk);
    chk("R4 -32768 x -1 clamps", int'($signed(out_i)), 32767);

    // directed: gain-2 clamp in bypass, R5
    t = '{1'b1,1'b0,2'd0,1'b1,1'b0,1'b0,16'sd20000,16'sd0};
    drive(t); model(t); @(negedge clk);
    chk("R5 doubled clamp", int'($signed(out_i)), 32767);

    // directed: sync to each even phase, R2
    for (int s = 0; s < 4; s++) begin
      t = '{1'b1,1'b1,2'(s),1'b0,1'b0,1'b1,16'sd8000,16'sd0};
      drive(t); model(t); @(negedge clk);
      check_out($sformatf("R2 start %0d", s));
    end

    // directed: hold over a gap, R8
    idle(); e_v = 0; @(negedge clk); @(negedge clk);
    check_out("R8 hold");

    // directed: mid-run reset returns phase to 0, R9
    t = '{1'b1,1'b0,2'd0,1'b0,1'b0,1'b1,16'sd1000,16'sd0};
    drive(t); model(t); @(negedge clk);
    do_reset();
    drive(t); model(t); @(negedge clk);
    chk("R9 phase 0 after reset I", int'($signed(out_i)), 1000);
    chk("R9 phase 0 after reset Q", int'($signed(out_q)), 0);
    drive(t); model(t); @(negedge clk);
    chk("R1 phase 1 I", int'($signed(out_i)), 707);
    chk("R1 phase 1 Q", int'($signed(out_q)), 707);
    idle();
    @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule